// File: doc/BRIEF.md
# Split Internal RAM Protection Unit

This block guards a 1 KB on-chip RAM that appears, repeated every 1 KB, across the CPU window $7000-$7FFF. The RAM is split into a lower and an upper 512-byte half, and each half has its own read permission and write permission. A master enable, taken from the bank index register, gates the whole window. For every CPU access the block decides whether the RAM is read, whether it is written, and what the CPU data bus sees: RAM data, a forced zero, or nothing driven (open bus).

Read permission and write permission combine as follows. A half is writable only when it is also readable. When exactly one half is readable, reads of the other half return zero instead of floating. The RAM is synchronous. The read and write enables go out in the cycle of the access. The bus result is registered and appears in the following cycle, together with the RAM's read data. Bank mapping is handled elsewhere.

Top module: `split_ram_guard`

## Requirements
- R1: An access whose address lies outside $7000-$7FFF (address bits 15:12 not equal to 4'h7) asserts neither `ramRdEn` nor `ramWrEn`, and `busDrive` is low in the following cycle.
- R2: Inside the window, `ramAddr` equals CPU address bits 9:0, so the 1 KB image repeats every $400 bytes. Address bit 9 clear selects the lower half and bit 9 set selects the upper half.
- R3: When `idxReg` bit 5 (master enable) is clear, every read in the window leaves the bus undriven and every write is blocked.
- R4: A read of the lower half with the master enable set and `ctlReg` bit 5 set asserts `ramRdEn`. In the next cycle `busDrive` is high and `busData` equals `ramRdData`.
- R5: A read of the upper half with the master enable set and `ctlReg` bit 7 set asserts `ramRdEn`. In the next cycle `busDrive` is high and `busData` equals `ramRdData`.
- R6: With the master enable set and neither `ctlReg` bit 5 nor bit 7 set, reads of both halves leave `busDrive` low and do not assert `ramRdEn`.
- R7: With the master enable set and exactly one half readable, a read of the other half does not assert `ramRdEn`. In the next cycle `busDrive` is high and `busData` is 0.
- R8: A write asserts `ramWrEn` only when the master enable is set and both the target half's read bit and its write bit are set. The bits are 5 and 4 for the lower half and 7 and 6 for the upper half.
- R9: After reset, and in any cycle that follows a cycle without a granted read, `busDrive` is low and `busData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuRd | input | 1 | CPU read strobe, one cycle per access |
| cpuWr | input | 1 | CPU write strobe, one cycle per access |
| idxReg | input | 8 | Bank index register (bit 5 is the master enable) |
| ctlReg | input | 8 | RAM control register (bits 7..4: upper read, upper write, lower read, lower write) |
| ramAddr | output | 10 | RAM byte address, 0 when no enable is asserted |
| ramRdEn | output | 1 | Synchronous RAM read enable |
| ramWrEn | output | 1 | Synchronous RAM write enable |
| ramRdData | input | 8 | RAM read data, valid the cycle after `ramRdEn` |
| busData | output | 8 | Data presented to the CPU for the previous cycle's read |
| busDrive | output | 1 | High when `busData` is actually driven (not open bus) |

## Verification
Two things can fall in the same cycle: the registered read result of one access and the write decision of the next access. The bench issues a granted read and follows it at once with a write to the other half. In that second cycle it checks that `ramWrEn` and `busDrive` are both high and that `busData` carries the first access's RAM byte. A later read-back then confirms that the written byte landed and the read byte was not disturbed. The same overlap is repeated with a forced-zero read followed by a blocked write, to show that the two decisions never borrow from each other.

// File: rtl/split_ram_guard_pkg.sv
package split_ram_guard_pkg;

  // Data source chosen for a CPU read
  typedef enum logic [1:0] {
    SRC_OPEN = 2'd0,
    SRC_ZERO = 2'd1,
    SRC_RAM  = 2'd2
  } srcSel_e;

  // Strobes from the access decoder to the bus datapath
  typedef struct packed {
    logic    rdEn;
    logic    wrEn;
    srcSel_e src;
  } accessStb_t;

  // Register bit positions the decoder relies on
  localparam int MASTER_BIT  = 5;
  localparam int LO_RD_BIT   = 5;
  localparam int LO_WR_BIT   = 4;
  localparam int HI_RD_BIT   = 7;
  localparam int HI_WR_BIT   = 6;

endpackage

// File: rtl/ram_guard_ctrl.sv
module ram_guard_ctrl
  import split_ram_guard_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int REG_W      = 8,
  parameter int RAM_BYTES  = 1024,
  parameter int WIN_BYTES  = 4096,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h7000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 cpuRd,
  input  logic                 cpuWr,
  input  logic [REG_W-1:0]     idxReg,
  input  logic [REG_W-1:0]     ctlReg,
  output logic [$clog2(RAM_BYTES)-1:0] ramAddr,
  output accessStb_t           stb
);

  localparam int RAM_AW  = $clog2(RAM_BYTES);
  localparam int WIN_LSB = $clog2(WIN_BYTES);
  localparam int HALF_BIT = RAM_AW - 1;
  localparam int HALVES  = 2;

  logic inRegion;
  logic masterOn;
  logic halfSel;
  logic [HALVES-1:0] halfRd;
  logic [HALVES-1:0] halfWr;
  logic thisRd, thisWr, otherRd;

  assign inRegion = (cpuAddr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign masterOn = idxReg[MASTER_BIT];
  assign halfSel  = cpuAddr[HALF_BIT];

  // Per-half permission bits: index 0 = lower half, 1 = upper half
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam int RD_POS = (h == 0) ? LO_RD_BIT : HI_RD_BIT;
    localparam int WR_POS = (h == 0) ? LO_WR_BIT : HI_WR_BIT;
    assign halfRd[h] = ctlReg[RD_POS];
    assign halfWr[h] = ctlReg[WR_POS];
  end

  assign thisRd  = halfRd[halfSel];
  assign thisWr  = halfWr[halfSel];
  assign otherRd = halfRd[~halfSel];

  always_comb begin
    stb.src  = SRC_OPEN;
    stb.rdEn = 1'b0;
    stb.wrEn = 1'b0;
    if (inRegion && masterOn) begin
      if (cpuRd) begin
        if (thisRd) begin
          stb.src  = SRC_RAM;
          stb.rdEn = 1'b1;
        end else if (otherRd) begin
          stb.src  = SRC_ZERO;
        end
      end
      if (cpuWr && thisRd && thisWr)
        stb.wrEn = 1'b1;
    end
  end

  assign ramAddr = (stb.rdEn || stb.wrEn) ? cpuAddr[RAM_AW-1:0] : '0;

  // Bits of the inputs this decoder does not look at
  logic unusedBits;
  assign unusedBits = ^{idxReg, ctlReg[LO_WR_BIT-1:0], cpuAddr[WIN_LSB-1:RAM_AW]};

  // R1
  out_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1:WIN_LSB] != WIN_BASE[ADDR_W-1:WIN_LSB]) |-> (!stb.rdEn && !stb.wrEn && stb.src == SRC_OPEN));

  // R3
  master_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idxReg[MASTER_BIT] |-> (stb.src == SRC_OPEN && !stb.wrEn));

  // R8
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> (cpuWr && (cpuAddr[HALF_BIT] ? (ctlReg[HI_RD_BIT] && ctlReg[HI_WR_BIT])
                                              : (ctlReg[LO_RD_BIT] && ctlReg[LO_WR_BIT]))));

  // R4
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |-> (cpuRd && stb.src == SRC_RAM));

endmodule

// File: rtl/ram_guard_dp.sv
module ram_guard_dp
  import split_ram_guard_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  srcSel_e           srcIn,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] busData,
  output logic              busDrive
);

  srcSel_e srcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcQ <= SRC_OPEN;
    else       srcQ <= srcIn;
  end

  always_comb begin
    busDrive = 1'b0;
    busData  = '0;
    unique case (srcQ)
      SRC_RAM: begin
        busDrive = 1'b1;
        busData  = ramRdData;
      end
      SRC_ZERO: busDrive = 1'b1;
      default: ;
    endcase
  end

  // R7
  zero_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcIn == SRC_ZERO) |=> (busDrive && busData == '0));

  // R6
  open_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcIn == SRC_OPEN) |=> (!busDrive && busData == '0));

  // R5
  ram_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcIn == SRC_RAM) |=> (busDrive && busData == ramRdData));

endmodule

// File: rtl/split_ram_guard.sv
module split_ram_guard
  import split_ram_guard_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int REG_W     = 8,
  parameter int RAM_BYTES = 1024,
  parameter int WIN_BYTES = 4096,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h7000,
  localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [REG_W-1:0]  idxReg,
  input  logic [REG_W-1:0]  ctlReg,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramRdEn,
  output logic              ramWrEn,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] busData,
  output logic              busDrive
);

  accessStb_t stb;

  ram_guard_ctrl #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .RAM_BYTES(RAM_BYTES),
    .WIN_BYTES(WIN_BYTES), .WIN_BASE(WIN_BASE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .idxReg(idxReg), .ctlReg(ctlReg), .ramAddr(ramAddr), .stb(stb)
  );

  ram_guard_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .srcIn(stb.src), .ramRdData(ramRdData),
    .busData(busData), .busDrive(busDrive)
  );

  assign ramRdEn = stb.rdEn;
  assign ramWrEn = stb.wrEn;

endmodule

// File: tb/split_ram_guard_tb_top.sv
`timescale 1ns/1ps
module split_ram_guard_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] cpuAddr;
  logic        cpuRd, cpuWr;
  logic [7:0]  cpuWrData;
  logic [7:0]  idxReg, ctlReg;
  logic [9:0]  ramAddr;
  logic        ramRdEn, ramWrEn;
  logic [7:0]  ramRdData;
  logic [7:0]  busData;
  logic        busDrive;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem    [1024];
  logic [7:0] shadow [1024];

  always #2.5 clk = ~clk;

  split_ram_guard dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .idxReg(idxReg), .ctlReg(ctlReg), .ramAddr(ramAddr), .ramRdEn(ramRdEn),
    .ramWrEn(ramWrEn), .ramRdData(ramRdData), .busData(busData), .busDrive(busDrive)
  );

  // Synchronous RAM model
  always @(posedge clk) begin
    if (ramWrEn) mem[ramAddr] <= cpuWrData;
    if (ramRdEn) ramRdData <= mem[ramAddr];
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected outcome from the requirements: 0 open, 1 zero, 2 RAM
  function automatic int expRead(input logic [15:0] a, input logic [7:0] idx, input logic [7:0] ctl);
    logic hi, rdThis, rdOther;
    if (a[15:12] != 4'h7 || !idx[5]) return 0;
    hi = a[9];
    rdThis  = hi ? ctl[7] : ctl[5];
    rdOther = hi ? ctl[5] : ctl[7];
    if (rdThis) return 2;
    if (rdOther) return 1;
    return 0;
  endfunction

  function automatic logic expWrite(input logic [15:0] a, input logic [7:0] idx, input logic [7:0] ctl);
    if (a[15:12] != 4'h7 || !idx[5]) return 1'b0;
    return a[9] ? (ctl[7] & ctl[6]) : (ctl[5] & ctl[4]);
  endfunction

  task automatic idle();
    cpuRd = 0; cpuWr = 0; cpuAddr = 16'h0000; cpuWrData = 8'h00;
  endtask

  // One read access: strobes in cycle 1, bus result in cycle 2
  task automatic doRead(input string req, input logic [15:0] a, input logic [7:0] idx, input logic [7:0] ctl);
    int e;
    @(negedge clk);
    idxReg = idx; ctlReg = ctl; cpuAddr = a; cpuRd = 1; cpuWr = 0;
    e = expRead(a, idx, ctl);
    #1;
    chk(req, "ramRdEn", {15'd0, ramRdEn}, {15'd0, e == 2});
    chk(req, "ramWrEn", {15'd0, ramWrEn}, 16'd0);
    if (e == 2) chk("R2", "ramAddr", {6'd0, ramAddr}, {6'd0, a[9:0]});
    @(negedge clk);
    idle();
    #1;
    chk(req, "busDrive", {15'd0, busDrive}, {15'd0, e != 0});
    chk(req, "busData", {8'd0, busData}, (e == 2) ? {8'd0, shadow[a[9:0]]} : 16'd0);
  endtask

  task automatic doWrite(input string req, input logic [15:0] a, input logic [7:0] d, input logic [7:0] idx, input logic [7:0] ctl);
    logic e;
    @(negedge clk);
    idxReg = idx; ctlReg = ctl; cpuAddr = a; cpuRd = 0; cpuWr = 1; cpuWrData = d;
    e = expWrite(a, idx, ctl);
    #1;
    chk(req, "ramWrEn", {15'd0, ramWrEn}, {15'd0, e});
    chk(req, "ramRdEn", {15'd0, ramRdEn}, 16'd0);
    if (e) begin
      chk("R2", "ramAddr", {6'd0, ramAddr}, {6'd0, a[9:0]});
      shadow[a[9:0]] = d;
    end
    @(negedge clk);
    idle();
    #1;
    chk("R9", "busDrive after write", {15'd0, busDrive}, 16'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R9", "busDrive in reset", {15'd0, busDrive}, 16'd0);
    chk("R9", "busData in reset", {8'd0, busData}, 16'd0);
  endtask

  task automatic t_outside();
    doRead("R1", 16'h6FFF, 8'h20, 8'hF0);
    doRead("R1", 16'h8000, 8'h20, 8'hF0);
    doWrite("R1", 16'h6123, 8'h11, 8'h20, 8'hF0);
  endtask

  task automatic t_mirror();
    doWrite("R8", 16'h7005, 8'hA5, 8'h20, 8'hF0);
    doRead("R2", 16'h7405, 8'h20, 8'hF0);
    doRead("R2", 16'h7C05, 8'h20, 8'hF0);
  endtask

  task automatic t_master_off();
    doRead("R3", 16'h7010, 8'hDF, 8'hF0);
    doRead("R3", 16'h7210, 8'h00, 8'hF0);
    doWrite("R3", 16'h7010, 8'h77, 8'hDF, 8'hF0);
  endtask

  task automatic t_halves();
    doRead("R4", 16'h7123, 8'h20, 8'h20);
    doRead("R5", 16'h7323, 8'h20, 8'h80);
    doRead("R6", 16'h7123, 8'h20, 8'h50);
    doRead("R6", 16'h7323, 8'h20, 8'h00);
    doRead("R7", 16'h7323, 8'h20, 8'h20);
    doRead("R7", 16'h7123, 8'h20, 8'h80);
  endtask

  task automatic t_write_matrix();
    for (int c = 0; c < 16; c++) begin
      doWrite("R8", 16'h7040, 8'(8'h30 + c), 8'h20, 8'(c << 4));
      doWrite("R8", 16'h7240, 8'(8'h60 + c), 8'h20, 8'(c << 4));
    end
    doRead("R8", 16'h7040, 8'h20, 8'hF0);
    doRead("R8", 16'h7240, 8'h20, 8'hF0);
  endtask

  // Read result of one access overlapping the write decision of the next
  task automatic t_overlap();
    @(negedge clk);
    idxReg = 8'h20; ctlReg = 8'hF0; cpuAddr = 16'h7011; cpuRd = 1; cpuWr = 0;
    @(negedge clk);
    cpuAddr = 16'h7211; cpuRd = 0; cpuWr = 1; cpuWrData = 8'hC3;
    #1;
    chk("R8", "overlap ramWrEn", {15'd0, ramWrEn}, 16'd1);
    chk("R4", "overlap busDrive", {15'd0, busDrive}, 16'd1);
    chk("R4", "overlap busData", {8'd0, busData}, {8'd0, shadow[10'h011]});
    shadow[10'h211] = 8'hC3;
    @(negedge clk);
    idle();
    // forced-zero read then blocked write
    @(negedge clk);
    ctlReg = 8'h80; cpuAddr = 16'h7011; cpuRd = 1;
    @(negedge clk);
    cpuAddr = 16'h7012; cpuRd = 0; cpuWr = 1; cpuWrData = 8'hEE;
    #1;
    chk("R8", "overlap blocked ramWrEn", {15'd0, ramWrEn}, 16'd0);
    chk("R7", "overlap zero busDrive", {15'd0, busDrive}, 16'd1);
    chk("R7", "overlap zero busData", {8'd0, busData}, 16'd0);
    @(negedge clk);
    idle();
    doRead("R4", 16'h7011, 8'h20, 8'hF0);
    doRead("R5", 16'h7211, 8'h20, 8'hF0);
    doRead("R8", 16'h7012, 8'h20, 8'hF0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    ramRdData = 8'h00;
    idxReg = 8'h00; ctlReg = 8'h00;
    idle();
    rstN = 0;
    t_reset();
    repeat (3) @(negedge clk);
    rstN = 1;
    t_outside();
    t_mirror();
    t_master_off();
    t_halves();
    t_write_matrix();
    t_overlap();
    finishRun();
  end

endmodule